// File: doc/BRIEF.md
# ADPCM Sample Nibble Feeder

This block feeds 4-bit ADPCM codes to an external ADPCM decoder from a byte-wide sample ROM. The sound CPU sets a 16-bit sample offset through two byte registers, low and high. It can read both bytes back at any time, and what it reads is the live value of the offset as it advances during playback. Each decoder request tick takes one nibble from the addressed byte. The first tick of a pair takes the upper nibble and the second takes the lower nibble. The second tick also moves the offset on to the next byte.

A third CPU register controls the decoder's reset line. The sense is inverted: writing any nonzero value releases the decoder, and writing zero holds it in reset. The ROM has synchronous reads with one cycle of latency, and the nibble output is registered. Ticks are expected at least two cycles apart. The offset should not be written in the cycle just before a tick, so that the ROM data has settled for the byte the tick consumes.

Top module: `adpcm_feed`

## Requirements
- R1: After reset the offset is 0x0000, the next tick takes the upper nibble, `nibble_o` is 0 and `dec_rst_o` is 1.
- R2: A write with `cpu_addr_i`=0 replaces offset bits 7:0, and a write with `cpu_addr_i`=1 replaces bits 15:8. Neither write changes the other byte.
- R3: `cpu_rdata_o` returns offset bits 7:0 when `cpu_addr_i`=0 and bits 15:8 when `cpu_addr_i`=1, including increments made by playback, in the same cycle.
- R4: `rom_addr_o` always equals offset bits 14:0, so bit 15 never reaches the ROM.
- R5: On a tick in the upper phase, `nibble_o` takes `rom_data_i[7:4]` as sampled at the tick edge. It shows that value from the next cycle and holds it until the next tick.
- R6: On a tick in the lower phase, `nibble_o` takes `rom_data_i[3:0]` and the offset increments by one at the same edge.
- R7: The increment spans all 16 bits and wraps from 0xFFFF to 0x0000.
- R8: A write with `cpu_addr_i`=2 sets `dec_rst_o` to 0 when the data is nonzero and to 1 when it is zero. The level is held until the next such write.
- R9: When a byte write and an increment fall on the same edge, the written byte replaces that byte of the incremented offset, and the other byte keeps its incremented value.
- R10: The nibble phase flips on every tick and is not changed by offset writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_we_i | input | 1 | CPU register write strobe |
| cpu_addr_i | input | 2 | Register select: 0 offset low, 1 offset high, 2 decoder reset control |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Offset byte chosen by `cpu_addr_i` (0 for other selects) |
| rom_addr_o | output | 15 | Sample ROM byte address |
| rom_data_i | input | 8 | Sample ROM data, one cycle after the address |
| tick_i | input | 1 | Decoder request tick |
| nibble_o | output | 4 | Registered ADPCM code |
| dec_rst_o | output | 1 | Decoder reset, active high |

## Verification
Two functions can fall on the same edge: a CPU write to one offset byte and the increment caused by a lower-phase tick. The bench provokes this by driving a tick in the lower phase together with a write to the low byte, and again together with a write to the high byte. It also drives a write together with an upper-phase tick, where no increment happens. The bench then reads both bytes back and judges the result against a behavioural model, which applies the increment first and the byte overlay second. The same model checks every cycle that the nibble phase carries on across these writes.

// File: rtl/adpcm_feed_pkg.sv
package adpcm_feed_pkg;
  localparam int OFF_W  = 16;
  localparam int ADDR_W = 15;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int LANES  = OFF_W / BYTE_W;
  localparam int NIBS   = BYTE_W / NIB_W;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_OFF_LO = 2'd0,
    SEL_OFF_HI = 2'd1,
    SEL_DEC    = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/feed_offset_reg.sv
module feed_offset_reg #(
  parameter int OFF_W  = 16,
  parameter int BYTE_W = 8,
  parameter int LANES  = OFF_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              inc_i,
  output logic [OFF_W-1:0]  off_o
);
  logic [OFF_W-1:0] off_q, bumped, off_d;

  assign bumped = inc_i ? off_q + OFF_W'(1) : off_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign off_d[g*BYTE_W +: BYTE_W] = wr_i[g] ? wdata_i : bumped[g*BYTE_W +: BYTE_W];

    AST_LANE_OVERLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i[g] |=> off_q[g*BYTE_W +: BYTE_W] == $past(wdata_i)); // R9
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= '0;
    else         off_q <= off_d;
  end

  assign off_o = off_q;

  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && wr_i == '0) |=> off_q == $past(off_q) + OFF_W'(1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && wr_i == '0) |=> $stable(off_q)); // R2
endmodule

// File: rtl/feed_nibble_seq.sv
module feed_nibble_seq #(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  parameter int NIBS   = BYTE_W / NIB_W,
  parameter int PH_W   = (NIBS > 1) ? $clog2(NIBS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [NIB_W-1:0]  nibble_o,
  output logic              inc_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NIBS - 1);

  logic [PH_W-1:0]  phase_q;
  logic [NIB_W-1:0] nib_q;
  logic [NIB_W-1:0] nib_sel [NIBS];

  // phase 0 takes the most significant nibble
  for (genvar k = 0; k < NIBS; k++) begin : g_nib
    assign nib_sel[k] = byte_i[(NIBS-1-k)*NIB_W +: NIB_W];
  end

  assign inc_o = tick_i && (phase_q == LAST_PH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      nib_q   <= '0;
    end else if (tick_i) begin
      nib_q   <= nib_sel[phase_q];
      phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + PH_W'(1);
    end
  end

  assign nibble_o = nib_q;

  AST_PHASE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> phase_q != $past(phase_q)); // R10
  AST_NIB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(nib_q)); // R5
  AST_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_q)); // R10
endmodule

// File: rtl/feed_dec_ctrl.sv
module feed_dec_ctrl #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              dec_rst_o
);
  logic rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rst_q <= 1'b1;
    else if (we_i) rst_q <= (wdata_i == '0);
  end

  assign dec_rst_o = rst_q;

  AST_DEC_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> dec_rst_o == ($past(wdata_i) == '0)); // R8
  AST_DEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(dec_rst_o)); // R8
endmodule

// File: rtl/adpcm_feed.sv
module adpcm_feed
  import adpcm_feed_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic [SEL_W-1:0]  cpu_addr_i,
  input  logic [BYTE_W-1:0] cpu_wdata_i,
  output logic [BYTE_W-1:0] cpu_rdata_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [BYTE_W-1:0] rom_data_i,
  input  logic              tick_i,
  output logic [NIB_W-1:0]  nibble_o,
  output logic              dec_rst_o
);
  logic [OFF_W-1:0] off;
  logic [LANES-1:0] lane_wr;
  logic             inc;
  logic             dec_we;

  for (genvar g = 0; g < LANES; g++) begin : g_wr
    assign lane_wr[g] = cpu_we_i && (cpu_addr_i == SEL_W'(g));
  end
  assign dec_we = cpu_we_i && (cpu_addr_i == SEL_DEC);

  always_comb begin
    cpu_rdata_o = '0;
    for (int g = 0; g < LANES; g++)
      if (cpu_addr_i == SEL_W'(g)) cpu_rdata_o = off[g*BYTE_W +: BYTE_W];
  end

  assign rom_addr_o = off[ADDR_W-1:0];

  feed_offset_reg #(.OFF_W(OFF_W), .BYTE_W(BYTE_W), .LANES(LANES)) u_off (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (lane_wr),
    .wdata_i (cpu_wdata_i),
    .inc_i   (inc),
    .off_o   (off)
  );

  feed_nibble_seq #(.BYTE_W(BYTE_W), .NIB_W(NIB_W), .NIBS(NIBS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .byte_i   (rom_data_i),
    .nibble_o (nibble_o),
    .inc_o    (inc)
  );

  feed_dec_ctrl #(.BYTE_W(BYTE_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (dec_we),
    .wdata_i   (cpu_wdata_i),
    .dec_rst_o (dec_rst_o)
  );

  AST_ROM_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_wr[0] && !inc) |=> rom_addr_o[BYTE_W-1:0] == $past(cpu_wdata_i)); // R4
endmodule

// File: tb/tb_adpcm_feed.sv
module tb_adpcm_feed;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cpu_we_i = 1'b0;
  logic [1:0] cpu_addr_i = 2'd0;
  logic [7:0] cpu_wdata_i = 8'd0;
  logic [7:0] cpu_rdata_o;
  logic [14:0] rom_addr_o;
  logic [7:0] rom_q;
  logic       tick_i = 1'b0;
  logic [3:0] nibble_o;
  logic       dec_rst_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  int m_off, m_phase, m_nib, m_rst, m_rom;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int romf(input int a);
    return ((a * 37) ^ (a >> 7) ^ 8'h5A) & 8'hFF;
  endfunction

  always_ff @(posedge clk_i) rom_q <= 8'(romf(int'(rom_addr_o)));

  adpcm_feed dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o), .rom_addr_o(rom_addr_o),
    .rom_data_i(rom_q), .tick_i(tick_i), .nibble_o(nibble_o), .dec_rst_o(dec_rst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one clock: drive, model at the edge, compare after it
  task automatic step(input bit we, input int a, input int d, input bit tk);
    int cap, nxt;
    bit inc;
    cpu_we_i = we; cpu_addr_i = 2'(a); cpu_wdata_i = 8'(d); tick_i = tk;
    @(posedge clk_i);
    cap = m_rom;
    inc = tk && (m_phase == 1);
    if (tk) begin
      m_nib = (m_phase == 0) ? (cap >> 4) & 15 : cap & 15;
      m_phase ^= 1;
    end
    m_rom = romf(m_off & 16'h7FFF);
    nxt = inc ? (m_off + 1) & 16'hFFFF : m_off;
    if (we && a == 0) nxt = (nxt & 16'hFF00) | (d & 8'hFF);
    if (we && a == 1) nxt = (nxt & 16'h00FF) | ((d & 8'hFF) << 8);
    if (we && a == 2) m_rst = (d == 0) ? 1 : 0;
    m_off = nxt;
    @(negedge clk_i);
    cpu_we_i = 1'b0; tick_i = 1'b0;
    chk("R5 R6 nibble", int'(nibble_o), m_nib);
    chk("R4 rom addr", int'(rom_addr_o), m_off & 16'h7FFF);
    chk("R8 dec reset", int'(dec_rst_o), m_rst);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic play(input int n);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 1);
      step(0, 0, 0, 0);
    end
  endtask

  task automatic set_off(input int v);
    step(1, 0, v & 8'hFF, 0);
    step(1, 1, (v >> 8) & 8'hFF, 0);
    idle(1);
  endtask

  task automatic rd(input string req, input int a, input int exp);
    cpu_we_i = 1'b0; cpu_addr_i = 2'(a);
    #1;
    chk(req, int'(cpu_rdata_o), exp);
  endtask

  initial begin
    m_off = 0; m_phase = 0; m_nib = 0; m_rst = 1; m_rom = romf(0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 nibble", int'(nibble_o), 0);
    chk("R1 dec reset", int'(dec_rst_o), 1);
    chk("R1 rom addr", int'(rom_addr_o), 0);
    rd("R1 low byte", 0, 0);
    rd("R1 high byte", 1, 0);
    idle(2);
    play(2);

    // R2 byte writes
    set_off(16'h0000);
    step(1, 0, 8'h34, 0); idle(1);
    rd("R2 low write", 0, 8'h34);
    rd("R2 high untouched", 1, 8'h00);
    step(1, 1, 8'h12, 0); idle(1);
    rd("R2 high write", 1, 8'h12);
    rd("R2 low untouched", 0, 8'h34);

    // R3 live readback after playback
    play(6);
    rd("R3 low live", 0, 8'h37);
    rd("R3 high live", 1, 8'h12);

    // R7 wrap over 16 bits
    set_off(16'hFFFE);
    play(4);
    rd("R7 low wrap", 0, 8'h00);
    rd("R7 high wrap", 1, 8'h00);

    // R4 bit 15 dropped
    set_off(16'h8005);
    chk("R4 masked", int'(rom_addr_o), 16'h0005);

    // R9 write and increment on one edge
    play(1);
    step(1, 0, 8'hAA, 1); idle(1);
    rd("R9 low overlay", 0, 8'hAA);
    rd("R9 high incremented", 1, 8'h80);
    play(1);
    step(1, 1, 8'h7F, 1); idle(1);
    rd("R9 high overlay", 1, 8'h7F);
    rd("R9 low incremented", 0, 8'hAB);
    step(1, 0, 8'h10, 1); idle(1);
    rd("R9 no increment on upper tick", 0, 8'h10);

    // R10 phase survives writes
    step(1, 0, 8'h20, 0); idle(1);
    step(0, 0, 0, 1); idle(1);
    chk("R10 lower after write", int'(nibble_o), romf(16'h7F20) & 15);
    rd("R10 incremented", 0, 8'h21);

    // R8 inverted reset sense
    step(1, 2, 8'h00, 0);
    chk("R8 zero holds", int'(dec_rst_o), 1);
    step(1, 2, 8'h05, 0);
    chk("R8 nonzero releases", int'(dec_rst_o), 0);
    step(1, 2, 8'h80, 0); idle(2);
    chk("R8 held", int'(dec_rst_o), 0);
    step(1, 2, 8'h00, 0);
    chk("R8 back to reset", int'(dec_rst_o), 1);
    rd("R8 dec write leaves offset", 0, 8'h21);

    play(8);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule